// File: doc/BRIEF.md
# Micro Translation Buffer with Shared-Buffer Refill

This block is a small, fully associative translation cache placed in front of a larger shared translation buffer. Each requester side, instruction fetch or data access, gets its own instance. A requester presents a virtual page number. When a valid entry holds that number, the physical page number and the permission bits come back combinationally in the same cycle.

On a miss the block stalls the requester and sends the missing page number to the shared buffer over a valid/ready request channel. It then waits for a one-cycle response, writes the returned translation into a victim slot, and completes the lookup. Empty slots are always filled first. Once every slot is valid, the victim comes from a wrapping round-robin pointer or from a pseudo-random sequence. A configuration register selects between the two, and it holds round-robin after reset. A single-cycle invalidate pulse empties the whole buffer.

Top module: `xlat_ucache`

## Requirements
- R1: After synchronous reset every slot is empty, so any lookup misses, `mt_req_valid` is 0, and `hit` and `stall` are 0 while `lk_valid` is 0.
- R2: While `lk_valid` is 1 and a valid slot holds `lk_vpn`, `hit` is 1 and `stall` is 0 in that same cycle, and `out_ppn`/`out_perm` carry that slot's data. With `lk_valid` at 0, `hit` is 0. At most one slot matches any page number.
- R3: A lookup that misses drives `stall` to 1 in the same cycle. `mt_req_valid` rises after the next clock edge with `mt_req_vpn` equal to the missed page number, and both hold until the clock edge at which `mt_req_ready` is 1.
- R4: A response (`mt_rsp_valid` high for one cycle after the request is accepted) is installed at that edge. The held lookup then hits in the following cycle with the returned PPN and permission bits.
- R5: In either replacement mode, an install writes the lowest-numbered empty slot while one exists. All ten translations fetched into an empty buffer are present together afterwards.
- R6: Round-robin mode: an install into a full buffer replaces the slot at a pointer that starts at 0 and steps by one per such replacement, wrapping from the last slot back to slot 0.
- R7: Random mode: an install into a full buffer replaces exactly one existing translation, chosen by a free-running LFSR reduced modulo the entry count.
- R8: A one-cycle `flush_all` pulse makes every slot empty at the next edge, so every earlier translation misses afterwards.
- R9: When `flush_all` and an install coincide, the flush wins. The lookup still misses and a new request is issued after the next edge.
- R10: The replacement mode register resets to round-robin. A cycle with `cfg_wr`=1 loads `cfg_rand` into it, where 0 selects round-robin and 1 selects random.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load replacement mode register |
| cfg_rand | input | 1 | Mode value: 0 round-robin, 1 random |
| flush_all | input | 1 | Invalidate every slot |
| lk_valid | input | 1 | Lookup present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| hit | output | 1 | Lookup hit this cycle |
| stall | output | 1 | Lookup present but not yet translated |
| out_ppn | output | PPN_W | Physical page number on hit |
| out_perm | output | PERM_W | Permission bits on hit |
| mt_req_valid | output | 1 | Refill request to shared buffer |
| mt_req_ready | input | 1 | Shared buffer accepts request |
| mt_req_vpn | output | VPN_W | Page number being refilled |
| mt_rsp_valid | input | 1 | Refill data valid (one cycle) |
| mt_rsp_ppn | input | PPN_W | Returned physical page number |
| mt_rsp_perm | input | PERM_W | Returned permission bits |

## Verification
The assertions check every cycle that the request stays stable until accepted, that a miss with the refill engine idle raises a request, that a response followed by the same held lookup hits, that a flush leaves nothing hitting, and that matches are never duplicated. Victim choice cannot be seen at the ports. The bench therefore shows it through scenarios: round-robin eviction order across a wrap, free-slot-first filling, single eviction in random mode, and a flush that cancels an install. These rely on side-effect-free probes, in which `lk_valid` is raised and dropped between clock edges.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fill_st_e;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 10,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PPN_W-1:0]   wr_ppn,
  input  logic [PERM_W-1:0]  wr_perm,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               any_hit,
  output logic [PPN_W-1:0]   rd_ppn,
  output logic [PERM_W-1:0]  rd_perm
);
  logic [VPN_W-1:0]  vpn_q  [ENTRIES];
  logic [PPN_W-1:0]  ppn_q  [ENTRIES];
  logic [PERM_W-1:0] perm_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      vpn_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
  end

  always_comb begin
    rd_ppn  = '0;
    rd_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_ppn  = rd_ppn  | ({PPN_W{match_vec[i]}}  & ppn_q[i]);
      rd_perm = rd_perm | ({PERM_W{match_vec[i]}} & perm_q[i]);
    end
  end

  assign any_hit   = |match_vec;
  assign valid_vec = valid_q;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES            = 10,
  parameter int LFSR_W             = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
  localparam int IDX_W             = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_rand,
  input  logic               commit,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0]  rr_q;
  logic [LFSR_W-1:0] lfsr_q;
  logic              free_any;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  rand_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_W'(1);
    else     lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk) begin
    if (rst) rr_q <= '0;
    else if (commit && !free_any && !mode_rand) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + IDX_W'(1);
    end
  end

  assign rand_idx   = IDX_W'(lfsr_q % LFSR_W'(ENTRIES));
  assign victim_idx = free_any ? free_idx : (mode_rand ? rand_idx : rr_q);
endmodule

// File: rtl/xlat_ucache.sv
module xlat_ucache #(
  parameter int ENTRIES = 10,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4,
  parameter int LFSR_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rand,
  input  logic              flush_all,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic              stall,
  output logic [PPN_W-1:0]  out_ppn,
  output logic [PERM_W-1:0] out_perm,
  output logic              mt_req_valid,
  input  logic              mt_req_ready,
  output logic [VPN_W-1:0]  mt_req_vpn,
  input  logic              mt_rsp_valid,
  input  logic [PPN_W-1:0]  mt_rsp_ppn,
  input  logic [PERM_W-1:0] mt_rsp_perm
);
  import xlat_pkg::*;

  fill_st_e           state_q;
  logic [VPN_W-1:0]   miss_vpn_q;
  logic               mode_q;
  logic               install;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic               any_hit;

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= 1'b0;
    else if (cfg_wr) mode_q <= cfg_rand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      miss_vpn_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (lk_valid && !any_hit && !flush_all) begin
          state_q    <= ST_REQ;
          miss_vpn_q <= lk_vpn;
        end
        ST_REQ:  if (mt_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mt_rsp_valid) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign install = (state_q == ST_WAIT) && mt_rsp_valid && !flush_all;

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_cam (
    .clk(clk), .rst(rst), .flush(flush_all), .wr_en(install), .wr_idx(victim_idx),
    .wr_vpn(miss_vpn_q), .wr_ppn(mt_rsp_ppn), .wr_perm(mt_rsp_perm), .lk_vpn(lk_vpn),
    .match_vec(match_vec), .valid_vec(valid_vec), .any_hit(any_hit),
    .rd_ppn(out_ppn), .rd_perm(out_perm)
  );

  xlat_victim #(.ENTRIES(ENTRIES), .LFSR_W(LFSR_W)) u_victim (
    .clk(clk), .rst(rst), .mode_rand(mode_q), .commit(install),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  assign hit          = lk_valid && any_hit;
  assign stall        = lk_valid && !any_hit;
  assign mt_req_valid = (state_q == ST_REQ);
  assign mt_req_vpn   = miss_vpn_q;
endmodule

// File: rtl/xlat_ucache_chk.sv
module xlat_ucache_chk #(
  parameter int ENTRIES = 10,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst,
  input logic               flush_all,
  input logic               lk_valid,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic               hit,
  input logic               mt_req_valid,
  input logic               mt_req_ready,
  input logic [VPN_W-1:0]   mt_req_vpn,
  input logic               mt_rsp_valid,
  input logic [1:0]         fill_st,
  input logic [ENTRIES-1:0] match_vec,
  input logic [IDX_W-1:0]   victim_idx
);
  import xlat_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!mt_req_valid && !hit)); // R1
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst) $onehot0(match_vec)); // R2
  AST_MISS_REQUESTS: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !hit && !flush_all && fill_st == ST_IDLE) |=> (mt_req_valid && mt_req_vpn == $past(lk_vpn))); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mt_req_valid && !mt_req_ready) |=> (mt_req_valid && $stable(mt_req_vpn))); // R3
  AST_REFILL_HITS: assert property (@(posedge clk) disable iff (rst)
    (fill_st == ST_WAIT && mt_rsp_valid && !flush_all) |=>
    (!lk_valid || lk_vpn != $past(mt_req_vpn) || hit)); // R4
  AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (rst)
    victim_idx < IDX_W'(ENTRIES)); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush_all |=> !hit); // R8
endmodule

bind xlat_ucache xlat_ucache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst(rst), .flush_all(flush_all), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
  .hit(hit), .mt_req_valid(mt_req_valid), .mt_req_ready(mt_req_ready),
  .mt_req_vpn(mt_req_vpn), .mt_rsp_valid(mt_rsp_valid), .fill_st(state_q),
  .match_vec(match_vec), .victim_idx(victim_idx)
);

// File: tb/xlat_ucache_bench.sv
module xlat_ucache_bench;
  localparam int CLK_P = 10;
  localparam int N     = 10;

  logic clk = 0, rst = 1, cfg_wr = 0, cfg_rand = 0, flush_all = 0;
  logic lk_valid = 0;
  logic [19:0] lk_vpn = '0;
  logic hit, stall, mt_req_valid;
  logic [19:0] out_ppn, mt_req_vpn;
  logic [3:0] out_perm;
  logic mt_req_ready = 0, mt_rsp_valid = 0;
  logic [19:0] mt_rsp_ppn = '0;
  logic [3:0] mt_rsp_perm = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [19:0] model [N];

  xlat_ucache u_xlat_ucache (.*);

  initial forever #(CLK_P/2) clk = ~clk;

  function automatic logic [19:0] f_ppn(logic [19:0] v); return v ^ 20'h5A3C1; endfunction
  function automatic logic [3:0]  f_perm(logic [19:0] v); return v[3:0] ^ 4'h9; endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // side-effect-free probe: lk_valid is dropped before the next edge
  task automatic expect_present(logic [19:0] v, bit present, string req);
    bit h; logic [19:0] p; logic [3:0] pm;
    @(negedge clk); lk_valid = 1; lk_vpn = v; #1;
    h = hit; p = out_ppn; pm = out_perm;
    lk_valid = 0;
    check(h == present, req, {31'd0, h}, {31'd0, present});
    if (present && h) check(p == f_ppn(v) && pm == f_perm(v), req, {8'd0, p, pm}, {8'd0, f_ppn(v), f_perm(v)});
  endtask

  task automatic fetch(logic [19:0] v, int delay, bit flush_mid);
    @(negedge clk); lk_valid = 1; lk_vpn = v; #1;
    check(stall && !hit, "R3 stall on miss", {30'd0, stall, hit}, 32'h2);
    @(negedge clk);
    check(mt_req_valid && mt_req_vpn == v, "R3 request", {11'd0, mt_req_valid, mt_req_vpn}, {11'd0, 1'b1, v});
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check(mt_req_valid && mt_req_vpn == v, "R3 hold", {11'd0, mt_req_valid, mt_req_vpn}, {11'd0, 1'b1, v});
    end
    mt_req_ready = 1; @(negedge clk); mt_req_ready = 0;
    check(!mt_req_valid && stall, "R4 waiting", {30'd0, mt_req_valid, stall}, 32'h1);
    mt_rsp_ppn = f_ppn(v); mt_rsp_perm = f_perm(v);
    if (flush_mid) begin
      mt_rsp_valid = 1; flush_all = 1;
      @(negedge clk); mt_rsp_valid = 0; flush_all = 0; #1;
      check(!hit && stall, "R9 flush beats install", {30'd0, hit, stall}, 32'h1);
      @(negedge clk);
      check(mt_req_valid && mt_req_vpn == v, "R9 re-request", {31'd0, mt_req_valid}, 32'h1);
      mt_req_ready = 1; @(negedge clk); mt_req_ready = 0;
    end
    mt_rsp_valid = 1;
    @(negedge clk); mt_rsp_valid = 0; #1;
    check(hit && !stall && out_ppn == f_ppn(v) && out_perm == f_perm(v), "R4 hit after refill",
          {7'd0, hit, stall, out_ppn, out_perm}, {7'd0, 1'b1, 1'b0, f_ppn(v), f_perm(v)});
    lk_valid = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    check(!mt_req_valid && !hit && !stall, "R1 reset outputs", {29'd0, mt_req_valid, hit, stall}, 32'h0);
    expect_present(20'h00000, 0, "R1 empty after reset");
    expect_present(20'h00100, 0, "R1 empty after reset");
    // R5 fill an empty buffer
    for (int i = 0; i < N; i++) begin
      model[i] = 20'h00100 + 20'(i * 7);
      fetch(model[i], i % 3, 0);
    end
    for (int i = 0; i < N; i++) expect_present(model[i], 1, "R5 all ten present, R2 data");
    // R6 / R10 round-robin after reset, crossing the wrap
    for (int k = 0; k < 12; k++) begin
      logic [19:0] nv, old;
      int slot;
      nv = 20'h02000 + 20'(k); slot = k % N; old = model[slot];
      fetch(nv, 0, 0);
      expect_present(old, 0, "R6 R10 oldest evicted");
      expect_present(model[(slot + 1) % N], 1, "R6 next slot kept");
      model[slot] = nv;
      expect_present(nv, 1, "R6 new present");
    end
    // R8 flush
    @(negedge clk); flush_all = 1; @(negedge clk); flush_all = 0;
    for (int i = 0; i < N; i++) expect_present(model[i], 0, "R8 flushed");
    // R10 switch to random mode, R5 free-first still applies
    @(negedge clk); cfg_wr = 1; cfg_rand = 1; @(negedge clk); cfg_wr = 0;
    for (int i = 0; i < N; i++) begin
      model[i] = 20'h03000 + 20'(i);
      fetch(model[i], 0, 0);
    end
    for (int i = 0; i < N; i++) expect_present(model[i], 1, "R5 random mode fills empties first");
    // R7 random replacement evicts exactly one
    for (int k = 0; k < 6; k++) begin
      logic [19:0] nv;
      int misses, gone;
      nv = 20'h04000 + 20'(k); misses = 0; gone = 0;
      fetch(nv, 1, 0);
      for (int i = 0; i < N; i++) begin
        bit h;
        @(negedge clk); lk_valid = 1; lk_vpn = model[i]; #1; h = hit; lk_valid = 0;
        if (!h) begin misses++; gone = i; end
      end
      check(misses == 1, "R7 single eviction", 32'(misses), 32'd1);
      model[gone] = nv;
      expect_present(nv, 1, "R7 new present");
    end
    // R9 flush coincident with install
    fetch(20'h05000, 1, 1);
    expect_present(20'h05000, 1, "R9 later refill present");
    expect_present(model[0], 0, "R9 flush removed older");
    // R2 no lookup, no hit
    @(negedge clk); lk_valid = 0; lk_vpn = 20'h05000; #1;
    check(!hit && !stall, "R2 idle lookup", {30'd0, hit, stall}, 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule